// File: doc/BRIEF.md
# Posted-Write Timer Register Bridge

This block connects a fast bus-clock register port to a timer that runs on a slower, unrelated functional clock. Ten of the timer's registers live in the functional domain. Every write to one of them is carried across the boundary by a toggle handshake that goes through two-flop synchronizers in each direction. Each of these registers has its own write-pending flag, and the flags can be read together in a status register.

Software chooses the acknowledgement policy at run time through an interface control register. In non-posted mode a write to a synchronized register stalls the port, with ready held low, until the handshake has gone there and back. In posted mode the write is acknowledged at once and only its pending flag shows that it is still in flight. While that flag is set, a further write to the same register is acknowledged but discarded, and a read returns the value held before the write.

A soft reset started through the interface control register clears both domains and returns the bridge to non-posted mode. A system status register shows when the soft reset has finished. The remaining registers sit in the bus domain and take effect immediately.

Top module: `tmr_wbridge`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. The pending status register reads 0, the system status register reads 1, and the interface control register reads 0 (non-posted). Every synchronized register and every fregs_o slice reads 0.
- R2: Synchronized registers sit at addresses 0 to 9: control, counter, load, trigger, match, positive tick, negative tick, tick count, interrupt-mask set and interrupt-mask count. In non-posted mode a write to one of them keeps req_ready low until the handshake has returned. When it is accepted, its pending bit is 0 and a read returns the new value.
- R3: In posted mode, a write to a synchronized register whose pending bit is clear is accepted in its first cycle. Bit n of the pending status register (address 0x11) reads 1 from the cycle after acceptance and clears once the handshake has returned.
- R4: In posted mode, a write to a synchronized register whose pending bit is set is acknowledged without stall and discarded. After the bit clears, the register holds the first value.
- R5: While its pending bit is set, a read of a synchronized register returns the previous value. After the bit clears, the read returns the new value and the register's fregs_o slice (bits n*32 upward) carries it.
- R6: Each synchronized register has its own pending bit, and several bits can be set at once.
- R7: The interface control (0x10), pending status (0x11), system status (0x12) and direct storage registers (0x13 to 0x16) have no pending bit. A write to a storage register reads back in the very next access. Writes to 0x11 and 0x12 are ignored.
- R8: Bit 2 of the interface control register enables posted mode and reads back. Writing 0 selects non-posted mode.
- R9: A write to the interface control register with bit 1 set (for example 0x06) starts a soft reset; the write stalls while any pending bit is set. While the reset runs, writes stall and the system status register reads 0; afterwards it reads 1. The reset leaves the bridge in non-posted mode with the synchronized registers, fregs_o and the storage registers at 0.
- R10: rsp_valid is 1 in the single cycle after a read is accepted, and rsp_rdata carries the read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| fclk | input | 1 | Timer functional clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Register word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| fregs_o | output | NSYNC*DW | Functional-domain register values, register n at bits n*DW upward |

## Verification
The bench uses the default parameters: 32-bit data, a 5-bit address, ten synchronized registers and four storage registers. It runs the same sequence twice, first with the functional clock equal to the bus clock and then eight times slower. The slow phase widens the pending window enough to see several pending bits together and a long stale-read window. The fast phase checks that the drop and stale behaviour still hold when the round trip is only a few bus cycles. Stall lengths, poll counts and soft-reset completion are bounded for each ratio.

// File: rtl/tmr_wbridge_pkg.sv
package tmr_wbridge_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_WAIT} bstate_e;

    // interface control fields
    localparam int IFC_SRST_BIT = 1;
    localparam int IFC_POST_BIT = 2;

    // bus-domain register addresses
    localparam int ADR_IFCTRL = 16;
    localparam int ADR_PEND   = 17;
    localparam int ADR_SYSST  = 18;
    localparam int ADR_DIR0   = 19;
endpackage

// File: rtl/tmr_wbridge_sync2.sv
module tmr_wbridge_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/tmr_wbridge_chan.sv
module tmr_wbridge_chan #(
    parameter int DW = 32
) (
    input  logic          bclk,
    input  logic          fclk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          bclr_i,
    input  logic          fclr_i,
    output logic          pend_o,
    output logic [DW-1:0] landed_o,
    output logic [DW-1:0] fval_o
);
    typedef struct packed {
        logic          req;
        logic          seen;
        logic [DW-1:0] hold;
        logic [DW-1:0] landed;
    } bside_t;

    typedef struct packed {
        logic          ack;
        logic [DW-1:0] fval;
    } fside_t;

    bside_t b_d, b_q;
    fside_t f_d, f_q;
    logic   req_f, ack_b;

    tmr_wbridge_sync2 u_req_sync (.clk(fclk), .rst_n(rst_n), .d(b_q.req), .q(req_f));
    tmr_wbridge_sync2 u_ack_sync (.clk(bclk), .rst_n(rst_n), .d(f_q.ack), .q(ack_b));

    always_comb begin
        b_d = b_q;
        if (launch_i) begin
            b_d.req  = ~b_q.req;
            b_d.hold = wdata_i;
        end
        if (ack_b != b_q.seen) begin
            b_d.seen   = ack_b;
            b_d.landed = b_q.hold;
        end
        if (bclr_i) begin
            b_d.landed = '0;
        end
    end

    always_comb begin
        f_d = f_q;
        if (fclr_i) begin
            f_d.fval = '0;
        end
        if (req_f != f_q.ack) begin
            f_d.ack  = req_f;
            f_d.fval = b_q.hold;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign pend_o   = b_q.req ^ b_q.seen;
    assign landed_o = b_q.landed;
    assign fval_o   = f_q.fval;
endmodule

// File: rtl/tmr_wbridge.sv
module tmr_wbridge
    import tmr_wbridge_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 5,
    parameter int NSYNC = 10,
    parameter int NDIR  = 4
) (
    input  logic                bclk,
    input  logic                fclk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_rdata,
    output logic [NSYNC*DW-1:0] fregs_o
);
    localparam int IW  = $clog2(NSYNC);
    localparam int PW  = 2 ** IW;
    localparam int DIW = (NDIR > 1) ? $clog2(NDIR) : 1;

    typedef struct packed {
        bstate_e                 st;
        logic                    posted;
        logic [NDIR-1:0][DW-1:0] dreg;
        logic                    rvalid;
        logic [DW-1:0]           rdata;
        logic                    srst_req;
        logic                    srst_seen;
    } bus_t;

    bus_t              b_d, b_q;
    logic [PW-1:0]     launch;
    logic [PW-1:0]     pend_pad;
    logic [NSYNC-1:0]  pend;
    logic [DW-1:0]     landed [PW];
    logic [IW-1:0]     idx;
    logic [AW-1:0]     doff;
    logic [DIW-1:0]    dsel;
    logic              is_sync, is_ifc, is_pend, is_sysst, is_dir;
    logic              acc, srst_busy, clear_b, clear_f;
    logic              srst_rq_f, srst_ack_b, f_ack_q;
    logic              mode_posted, st_wait;

    assign idx      = req_addr[IW-1:0];
    assign doff     = req_addr - AW'(ADR_DIR0);
    assign dsel     = doff[DIW-1:0];
    assign is_sync  = (req_addr < AW'(NSYNC));
    assign is_ifc   = (req_addr == AW'(ADR_IFCTRL));
    assign is_pend  = (req_addr == AW'(ADR_PEND));
    assign is_sysst = (req_addr == AW'(ADR_SYSST));
    assign is_dir   = (req_addr >= AW'(ADR_DIR0)) && (req_addr < AW'(ADR_DIR0 + NDIR));

    assign mode_posted = b_q.posted;
    assign st_wait     = (b_q.st == ST_WAIT);
    assign srst_busy   = b_q.srst_req ^ b_q.srst_seen;
    assign clear_b     = (srst_ack_b != b_q.srst_seen);
    assign pend_pad    = PW'(pend);

    // per-register crossing channels; unused index slots tie off
    for (genvar i = 0; i < PW; i++) begin : g_ch
        if (i < NSYNC) begin : g_real
            tmr_wbridge_chan #(.DW(DW)) u_chan (
                .bclk     (bclk),
                .fclk     (fclk),
                .rst_n    (rst_n),
                .launch_i (launch[i]),
                .wdata_i  (req_wdata),
                .bclr_i   (clear_b),
                .fclr_i   (clear_f),
                .pend_o   (pend[i]),
                .landed_o (landed[i]),
                .fval_o   (fregs_o[i*DW +: DW])
            );
        end else begin : g_tie
            assign landed[i] = '0;
        end
    end

    // soft-reset handshake
    tmr_wbridge_sync2 u_srst_f (.clk(fclk), .rst_n(rst_n), .d(b_q.srst_req), .q(srst_rq_f));
    tmr_wbridge_sync2 u_srst_b (.clk(bclk), .rst_n(rst_n), .d(f_ack_q), .q(srst_ack_b));

    assign clear_f = (srst_rq_f != f_ack_q);

    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) f_ack_q <= 1'b0;
        else        f_ack_q <= srst_rq_f;
    end

    always_comb begin
        b_d       = b_q;
        b_d.rvalid = 1'b0;
        launch    = '0;

        req_ready = 1'b1;
        if (st_wait)                                                   req_ready = !pend_pad[idx];
        else if (req_write && srst_busy)                               req_ready = 1'b0;
        else if (req_write && is_sync && !mode_posted)                 req_ready = 1'b0;
        else if (req_write && is_ifc && req_wdata[IFC_SRST_BIT] && |pend) req_ready = 1'b0;
        acc = req_valid && req_ready;

        // non-posted: launch, then hold the port until the round trip ends
        if (!st_wait && req_valid && req_write && is_sync && !mode_posted
            && !srst_busy && !pend_pad[idx]) begin
            launch[idx] = 1'b1;
            b_d.st      = ST_WAIT;
        end
        if (st_wait && acc) begin
            b_d.st = ST_IDLE;
        end

        if (acc && req_write) begin
            if (is_sync && mode_posted && !pend_pad[idx]) begin
                launch[idx] = 1'b1;
            end
            if (is_ifc) begin
                if (req_wdata[IFC_SRST_BIT]) begin
                    b_d.posted   = 1'b0;
                    b_d.srst_req = ~b_q.srst_req;
                end else begin
                    b_d.posted = req_wdata[IFC_POST_BIT];
                end
            end
            if (is_dir) begin
                b_d.dreg[dsel] = req_wdata;
            end
        end

        if (acc && !req_write) begin
            b_d.rvalid = 1'b1;
            if (is_sync)       b_d.rdata = landed[idx];
            else if (is_ifc)   b_d.rdata = DW'({mode_posted, 2'b00});
            else if (is_pend)  b_d.rdata = DW'(pend);
            else if (is_sysst) b_d.rdata = DW'(!srst_busy);
            else if (is_dir)   b_d.rdata = b_q.dreg[dsel];
            else               b_d.rdata = '0;
        end

        if (clear_b) begin
            b_d.srst_seen = srst_ack_b;
            b_d.dreg      = '0;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            b_q    <= '0;
            b_q.st <= ST_IDLE;
        end else begin
            b_q <= b_d;
        end
    end

    assign rsp_valid = b_q.rvalid;
    assign rsp_rdata = b_q.rdata;
endmodule

// File: rtl/tmr_wbridge_chk.sv
module tmr_wbridge_chk #(
    parameter int AW    = 5,
    parameter int NSYNC = 10,
    parameter int PW    = 16
) (
    input logic             bclk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             posted,
    input logic             srst_busy,
    input logic             st_wait,
    input logic [NSYNC-1:0] pend,
    input logic [PW-1:0]    launch
);
    localparam int IW = $clog2(PW);

    logic          acc, sync_a;
    logic [PW-1:0] pp;
    logic [IW-1:0] ix;

    assign acc    = req_valid && req_ready;
    assign sync_a = (req_addr < AW'(NSYNC));
    assign pp     = PW'(pend);
    assign ix     = req_addr[IW-1:0];

    // R3
    posted_pend_set_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (acc && req_write && sync_a && posted && !pp[ix]) |=> pp[$past(ix)]);

    // R4
    posted_drop_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (acc && req_write && sync_a && posted && pp[ix]) |-> (launch == '0));

    // R2
    nonposted_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (req_valid && req_write && sync_a && !posted && !st_wait) |-> !req_ready);

    // R9
    srst_stall_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (srst_busy && req_valid && req_write) |-> !req_ready);

    // R10
    rsp_after_read_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (acc && !req_write) |=> rsp_valid);

    // R10
    rsp_only_read_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !(acc && !req_write) |=> !rsp_valid);

    // R6
    launch_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        $onehot0(launch));
endmodule

bind tmr_wbridge tmr_wbridge_chk #(.AW(AW), .NSYNC(NSYNC), .PW(PW)) u_chk (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .posted    (mode_posted),
    .srst_busy (srst_busy),
    .st_wait   (st_wait),
    .pend      (pend),
    .launch    (launch)
);

// File: tb/tmr_wbridge_bench.sv
module tmr_wbridge_bench;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NS = 10;
    localparam logic [AW-1:0] A_CTRL = 5'd0, A_CNT = 5'd1, A_LOAD = 5'd2, A_MATCH = 5'd4;
    localparam logic [AW-1:0] A_IFC = 5'd16, A_PEND = 5'd17, A_SYS = 5'd18, A_STO1 = 5'd20;

    logic bclk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
    int   fhalf = 10;

    always #10 bclk = ~bclk;
    initial begin
        #3;
        forever #(fhalf) fclk = ~fclk;
    end

    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic             req_ready, rsp_valid;
    logic [DW-1:0]    rsp_rdata;
    logic [NS*DW-1:0] fregs_o;

    tmr_wbridge u_tmr_wbridge (
        .bclk(bclk), .fclk(fclk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fregs_o(fregs_o)
    );

    int   checks = 0, fails = 0, cyc = 0;
    logic exp_rsp = 1'b0;
    logic [DW-1:0] model_reg [NS];

    always @(posedge bclk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // R10: response presence compared on every clock against the model
    always @(negedge bclk) begin
        if (rst_n) begin
            checks++;
            if (rsp_valid !== exp_rsp) begin
                fails++;
                $display("FAIL R10 rsp_valid actual %0b expected %0b", rsp_valid, exp_rsp);
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stall);
        @(negedge bclk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        stall = 0;
        #2;
        while (!req_ready) begin
            @(negedge bclk);
            #2;
            stall++;
        end
        @(posedge bclk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge bclk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #2;
        while (!req_ready) begin
            @(negedge bclk);
            #2;
        end
        @(posedge bclk);
        #1;
        req_valid = 1'b0;
        exp_rsp = 1'b1;
        @(negedge bclk);
        d = rsp_rdata;
        #1;
        exp_rsp = 1'b0;
    endtask

    task automatic poll_clear(input int b, output int n);
        logic [DW-1:0] v;
        n = 0;
        do begin
            rd(A_PEND, v);
            n++;
        end while (v[b] && n < 200);
    endtask

    task automatic run_phase(input int ph, input int mins, input int maxs, input bit slow);
        int st, n;
        logic [DW-1:0] v;
        logic [DW-1:0] va, vb, vc, vd;
        va = 32'hA000_0000 + DW'(ph);
        vb = 32'hB000_0000 + DW'(ph);
        vc = 32'hC000_0000 + DW'(ph);
        vd = 32'hD000_0000 + DW'(ph);

        // R2 non-posted write stalls for the round trip
        wr(A_LOAD, va, st);
        chk("R2 non-posted stall within bounds", DW'(st >= mins && st <= maxs), 32'd1);
        rd(A_PEND, v);
        chk("R2 pending clear at acceptance", v, 32'd0);
        rd(A_LOAD, v);
        chk("R2 load readback", v, va);
        model_reg[A_LOAD] = va;

        // R8 posted enable
        wr(A_IFC, 32'h4, st);
        chk("R8 interface control write not stalled", DW'(st), 32'd0);
        rd(A_IFC, v);
        chk("R8 posted bit readback", v, 32'h4);

        // R3 posted accept, R4 overlapping write, R5 stale read
        wr(A_MATCH, vb, st);
        chk("R3 posted write accepted at once", DW'(st), 32'd0);
        wr(A_MATCH, vc, st);
        chk("R4 overlapping write acknowledged at once", DW'(st), 32'd0);
        rd(A_MATCH, v);
        chk("R5 stale read while pending", v, model_reg[A_MATCH]);
        rd(A_PEND, v);
        chk("R3 match pending bit set", DW'(v[4]), 32'd1);
        if (slow) begin
            wr(A_CNT, vd, st);
            rd(A_PEND, v);
            chk("R6 two pending bits together", v, 32'h12);
            rd(A_PEND, v);
            chk("R3 pending bit held in slow domain", DW'(v[4]), 32'd1);
            poll_clear(1, n);
            chk("R3 counter pending clears within bound", DW'(n <= 30), 32'd1);
            rd(A_CNT, v);
            chk("R6 counter landed", v, vd);
            model_reg[A_CNT] = vd;
        end
        poll_clear(4, n);
        chk("R3 match pending clears within bound", DW'(n <= 30), 32'd1);
        rd(A_MATCH, v);
        chk("R4 first value kept, second dropped", v, vb);
        chk("R5 functional copy carries new value", fregs_o[4*DW +: DW], vb);
        model_reg[A_MATCH] = vb;

        // R7 direct registers
        wr(A_STO1, vd, st);
        chk("R7 storage write not stalled", DW'(st), 32'd0);
        rd(A_STO1, v);
        chk("R7 storage readback", v, vd);
        wr(A_PEND, 32'hFFFF_FFFF, st);
        rd(A_PEND, v);
        chk("R7 pending status ignores writes", v, 32'd0);
        wr(A_SYS, 32'd0, st);
        rd(A_SYS, v);
        chk("R7 system status ignores writes", v, 32'd1);

        // R8 back to non-posted
        wr(A_IFC, 32'h0, st);
        rd(A_IFC, v);
        chk("R8 non-posted selected", v, 32'd0);
        wr(A_CTRL, va, st);
        chk("R8 non-posted stall resumes", DW'(st >= mins), 32'd1);

        // R9 soft reset
        wr(A_IFC, 32'h4, st);
        wr(A_IFC, 32'h6, st);
        rd(A_SYS, v);
        chk("R9 system status low during reset", v, 32'd0);
        n = 0;
        do begin
            rd(A_SYS, v);
            n++;
        end while (v == 0 && n < 200);
        chk("R9 reset completes within bound", DW'(n <= 30), 32'd1);
        rd(A_IFC, v);
        chk("R9 reset returns to non-posted", v, 32'd0);
        rd(A_MATCH, v);
        chk("R9 match cleared", v, 32'd0);
        rd(A_CTRL, v);
        chk("R9 control cleared", v, 32'd0);
        rd(A_STO1, v);
        chk("R9 storage cleared", v, 32'd0);
        chk("R9 functional copies cleared", DW'(fregs_o != '0), 32'd0);
        for (int i = 0; i < NS; i++) model_reg[i] = '0;
        wr(A_LOAD, vc, st);
        chk("R9 non-posted stall after reset", DW'(st >= mins), 32'd1);
        model_reg[A_LOAD] = vc;
    endtask

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < NS; i++) model_reg[i] = '0;
        repeat (3) @(posedge bclk);
        #1;
        rst_n = 1'b1;
        @(negedge bclk);
        chk("R1 ready after reset", DW'(req_ready), 32'd1);
        chk("R1 no response after reset", DW'(rsp_valid), 32'd0);
        chk("R1 functional copies zero", DW'(fregs_o != '0), 32'd0);
        rd(A_PEND, v);
        chk("R1 pending status zero", v, 32'd0);
        rd(A_SYS, v);
        chk("R1 system status done", v, 32'd1);
        rd(A_IFC, v);
        chk("R1 non-posted after reset", v, 32'd0);
        rd(A_LOAD, v);
        chk("R1 load zero", v, 32'd0);

        run_phase(1, 3, 12, 1'b0);   // functional clock equal to bus clock
        fhalf = 80;                  // functional clock eight times slower
        run_phase(2, 12, 40, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule